// File: doc/BRIEF.md
# Port Pin Event Detector

This block watches every pin of a port and turns pin activity into status flags, a shared interrupt line and per-pin DMA requests. Each pin input is first passed through a two-flop synchroniser. The synchronised sample is then compared with the sample from the cycle before to detect rising and falling edges. A level test uses the synchronised sample directly.

Each pin has a 4-bit mode code. The code decides whether the pin is ignored, requests DMA on an edge, only records an edge in its flag, or interrupts on an edge or a level. Software clears flags by writing ones. A DMA engine retires a request by pulsing that pin's done strobe. Two group configuration writes load one mode code into every pin selected by a 16-bit mask, one write for each half of the port.

Top module: `pin_event_detect`

## Requirements
- R1: A pin change that is stable before clock edge k is seen by the synchroniser and updates the flag at edge k+2. The flag therefore reads 0 after two edges and 1 after the third edge.
- R2: Codes 1, 2 and 3 set the flag on a rising, falling or either edge. For a pin with one of these codes, `dma_req` for that pin equals its flag, and the pin never drives `irq`.
- R3: Codes 5, 6 and 7 set the flag on a rising, falling or either edge. These codes raise neither `irq` nor `dma_req`.
- R4: Code 8 sets the flag while the synchronised pin is 0, and code 12 sets it while the pin is 1. Codes 9, 10 and 11 set it on a rising, falling or either edge. `irq` is the OR of the flags of all pins whose code is in the range 8 to 12.
- R5: Codes 0, 4, 13, 14 and 15 never set a flag.
- R6: A clear write (`clr_we`) clears every flag whose bit in `clr_data` is 1. Bits written as 0 leave their flags unchanged.
- R7: A `dma_done` pulse clears the flag of a pin with code 1, 2 or 3. For any other code, the pulse has no effect on the flag.
- R8: When a pin's set condition is true in the same cycle as a clear, the set wins. A level-mode pin whose level persists therefore reads flagged again immediately after a clear.
- R9: A group write loads the code in data bits [19:16] into each selected pin. `glo_*` selects pins 0–15 through mask bits [15:0]. `ghi_*` selects pins 16–31, where mask bit j selects pin 16+j. A single-pin write (`cfg_we`) in the same cycle takes priority over a group write.
- R10: After reset, all codes are 0 and `flags`, `irq` and `dma_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 32 | Raw pin levels |
| cfg_we | input | 1 | Single-pin code write strobe |
| cfg_pin | input | 5 | Pin index for the single-pin write |
| cfg_code | input | 4 | Code for the single-pin write |
| glo_we | input | 1 | Group write strobe for pins 0–15 |
| glo_data | input | 20 | Group write: code in [19:16], pin mask in [15:0] |
| ghi_we | input | 1 | Group write strobe for pins 16–31 |
| ghi_data | input | 20 | Group write: code in [19:16], pin mask in [15:0] |
| clr_we | input | 1 | Flag clear strobe |
| clr_data | input | 32 | Write-one-to-clear mask |
| dma_done | input | 32 | Per-pin DMA completion pulses |
| flags | output | 32 | Status flags |
| irq | output | 1 | Combined interrupt |
| dma_req | output | 32 | Per-pin DMA requests |

## Verification
The assertions assume that `rst_n` is asserted at time zero and that `pin_in` may change in any cycle, because the synchroniser absorbs it. They assume that a clear, a done pulse and a configuration write can share a cycle with a set condition; the set-wins rule is stated so that such overlaps remain legal. The stimulus changes pins and strobes only on the falling clock edge. It holds each pin pattern for at least four cycles so that the edge and level outcomes settle before they are sampled. Deliberate overlaps of a clear with a live set condition are still included, to exercise R8.

// File: rtl/pin_event_detect.sv
`timescale 1ns/1ps
module pin_event_detect #(
  parameter int NPINS = 32,
  parameter int CW    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NPINS-1:0]           pin_in,
  input  logic                       cfg_we,
  input  logic [$clog2(NPINS)-1:0]   cfg_pin,
  input  logic [CW-1:0]              cfg_code,
  input  logic                       glo_we,
  input  logic [NPINS/2+CW-1:0]      glo_data,
  input  logic                       ghi_we,
  input  logic [NPINS/2+CW-1:0]      ghi_data,
  input  logic                       clr_we,
  input  logic [NPINS-1:0]           clr_data,
  input  logic [NPINS-1:0]           dma_done,
  output logic [NPINS-1:0]           flags,
  output logic                       irq,
  output logic [NPINS-1:0]           dma_req
);
  localparam int HALF = NPINS / 2;
  localparam int PW   = $clog2(NPINS);

  logic [NPINS-1:0] s1, s2, prev;
  logic [NPINS-1:0] rise, fall, set_v, dma_m, irq_m, gsel, clr_v;
  logic [CW-1:0]    code_q [NPINS];
  logic [CW-1:0]    lo_code, hi_code;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; prev <= '0;
    end else begin
      s1 <= pin_in; s2 <= s1; prev <= s2;
    end

  assign rise    = s2 & ~prev;
  assign fall    = ~s2 & prev;
  assign lo_code = glo_data[HALF+CW-1:HALF];
  assign hi_code = ghi_data[HALF+CW-1:HALF];
  assign gsel    = {ghi_we ? ghi_data[HALF-1:0] : {HALF{1'b0}},
                    glo_we ? glo_data[HALF-1:0] : {HALF{1'b0}}};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NPINS; i++) code_q[i] <= '0;
    end else begin
      for (int i = 0; i < NPINS; i++) begin
        if (cfg_we && cfg_pin == PW'(i)) code_q[i] <= cfg_code;
        else if (gsel[i]) code_q[i] <= (i < HALF) ? lo_code : hi_code;
      end
    end

  always_comb begin
    for (int i = 0; i < NPINS; i++) begin
      dma_m[i] = 1'b0;
      irq_m[i] = 1'b0;
      case (code_q[i])
        CW'(1), CW'(5), CW'(9):  set_v[i] = rise[i];
        CW'(2), CW'(6), CW'(10): set_v[i] = fall[i];
        CW'(3), CW'(7), CW'(11): set_v[i] = rise[i] | fall[i];
        CW'(8):                  set_v[i] = ~s2[i];
        CW'(12):                 set_v[i] = s2[i];
        default:                 set_v[i] = 1'b0;
      endcase
      if (code_q[i] >= CW'(1) && code_q[i] <= CW'(3))  dma_m[i] = 1'b1;
      if (code_q[i] >= CW'(8) && code_q[i] <= CW'(12)) irq_m[i] = 1'b1;
    end
  end

  assign clr_v = (clr_we ? clr_data : '0) | (dma_done & dma_m);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_v) | set_v;

  assign irq     = |(flags & irq_m);
  assign dma_req = flags & dma_m;
endmodule

// File: rtl/pin_event_detect_chk.sv
`timescale 1ns/1ps
module pin_event_detect_chk #(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] flags,
  input logic             irq,
  input logic [NPINS-1:0] dma_req,
  input logic [NPINS-1:0] set_v,
  input logic             clr_we,
  input logic [NPINS-1:0] clr_data
);
  assert_set_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_v) |=> ((flags & $past(set_v)) == $past(set_v)));

  assert_dma_only_flagged_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req & ~flags) == '0);

  assert_irq_needs_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags != '0));

  assert_no_spurious_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & ~$past(flags) & ~$past(set_v)) == '0);

  assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((flags & $past(clr_data) & ~$past(set_v)) == '0));
endmodule

bind pin_event_detect pin_event_detect_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .flags(flags), .irq(irq), .dma_req(dma_req),
  .set_v(set_v), .clr_we(clr_we), .clr_data(clr_data)
);

// File: tb/pin_event_detect_tb.sv
`timescale 1ns/1ps
module pin_event_detect_tb;
  logic        clk = 0, rst_n = 0;
  logic [31:0] pin_in = '0, clr_data = '0, dma_done = '0;
  logic        cfg_we = 0, glo_we = 0, ghi_we = 0, clr_we = 0;
  logic [4:0]  cfg_pin = '0;
  logic [3:0]  cfg_code = '0;
  logic [19:0] glo_data = '0, ghi_data = '0;
  logic [31:0] flags, dma_req;
  logic        irq;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  pin_event_detect u_dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cfg_we(cfg_we), .cfg_pin(cfg_pin),
    .cfg_code(cfg_code), .glo_we(glo_we), .glo_data(glo_data), .ghi_we(ghi_we),
    .ghi_data(ghi_data), .clr_we(clr_we), .clr_data(clr_data), .dma_done(dma_done),
    .flags(flags), .irq(irq), .dma_req(dma_req));

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_code(int p, int c);
    cfg_we = 1; cfg_pin = 5'(p); cfg_code = 4'(c);
    tick(1);
    cfg_we = 0;
  endtask

  task automatic clear_all();
    clr_we = 1; clr_data = '1;
    tick(1);
    clr_we = 0; clr_data = '0;
  endtask

  function automatic bit on_rise(int c); return c inside {1, 3, 5, 7, 9, 11}; endfunction
  function automatic bit on_fall(int c); return c inside {2, 3, 6, 7, 10, 11}; endfunction
  function automatic string req_of(int c);
    if (c >= 1 && c <= 3)  return "R2";
    if (c >= 5 && c <= 7)  return "R3";
    if (c >= 8 && c <= 12) return "R4";
    return "R5";
  endfunction

  task automatic expect_pin(int p, int c, bit f, string tag);
    logic [31:0] fv;
    fv = f ? (32'd1 << p) : 32'd0;
    chk(tag, flags, fv);
    chk("R4", {31'd0, irq}, {31'd0, f && c >= 8 && c <= 12});
    chk("R2", dma_req, (c >= 1 && c <= 3) ? fv : 32'd0);
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(2);
    chk("R10", flags, 0); chk("R10", {31'd0, irq}, 0); chk("R10", dma_req, 0);
    rst_n = 1;
    tick(2);
    chk("R10", flags, 0);

    // R1 exact latency
    set_code(3, 9);
    pin_in[3] = 1;
    tick(2); chk("R1", flags, 0);
    tick(1); chk("R1", flags, 32'h8);
    pin_in[3] = 0; set_code(3, 0); tick(4); clear_all(); tick(2);
    chk("R1", flags, 0);

    // sweep every code on three pins
    foreach (pin_in[k]) ;
    for (int c = 0; c < 16; c++) begin
      for (int s = 0; s < 3; s++) begin
        int p;
        p = (s == 0) ? 0 : (s == 1) ? 17 : 31;
        set_code(p, c);
        clear_all(); tick(4);
        expect_pin(p, c, c == 8, req_of(c));
        clr_we = 1; clr_data = '1; pin_in[p] = 1; tick(1); clr_we = 0; clr_data = '0;
        tick(4);
        expect_pin(p, c, c == 8 || c == 12 || on_rise(c), req_of(c));
        clear_all(); tick(4);
        expect_pin(p, c, c == 12, "R8");
        clr_we = 1; clr_data = '1; pin_in[p] = 0; tick(1); clr_we = 0; clr_data = '0;
        tick(4);
        expect_pin(p, c, c == 8 || c == 12 || on_fall(c), req_of(c));
        clear_all(); tick(4);
        expect_pin(p, c, c == 8, "R8");
        set_code(p, 0); clear_all(); tick(1);
      end
    end

    // R9 group writes
    glo_we = 1; glo_data = {4'd9, 16'h0005};
    ghi_we = 1; ghi_data = {4'd10, 16'h8001};
    tick(1); glo_we = 0; ghi_we = 0;
    pin_in = '1; tick(4);
    chk("R9", flags, 32'h0000_0005); chk("R9", {31'd0, irq}, 1);
    clr_we = 1; clr_data = '1; pin_in = '0; tick(1); clr_we = 0; clr_data = '0;
    tick(4);
    chk("R9", flags, 32'h8001_0000); chk("R9", {31'd0, irq}, 1);
    glo_we = 1; glo_data = {4'd0, 16'hFFFF};
    ghi_we = 1; ghi_data = {4'd0, 16'hFFFF};
    tick(1); glo_we = 0; ghi_we = 0;
    clear_all(); tick(2);
    chk("R9", flags, 0);

    // R7 / R6 on DMA and interrupt pins
    set_code(5, 1);
    pin_in[5] = 1; tick(4);
    chk("R2", dma_req, 32'h20);
    clr_we = 1; clr_data = ~32'h20; tick(1); clr_we = 0; clr_data = '0;
    chk("R6", flags, 32'h20);
    dma_done[5] = 1; tick(1); dma_done = '0;
    chk("R7", flags, 0); chk("R7", dma_req, 0);
    set_code(6, 9);
    pin_in[6] = 1; tick(4);
    chk("R4", flags, 32'h40);
    dma_done[6] = 1; tick(1); dma_done = '0;
    chk("R7", flags, 32'h40);
    clr_we = 1; clr_data = 32'h40; tick(1); clr_we = 0; clr_data = '0;
    chk("R6", flags, 0); chk("R6", {31'd0, irq}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule